// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Controller

This block sits on the master side of a synchronous SRAM. It takes single read and write requests over a valid/ready handshake. Each request carries an address, write data and a byte mask. The block turns each request into pin activity with late-write timing: a write presents its address on one cycle and its data, byte enables and write enable on the next. Reads support either zero or one wait state, chosen by the `cfg_wait` input. That input must match the way the memory's output stage is strapped. It may change only while reset is held.

The memory data bus is split into `mem_dq_out`, `mem_dq_in` and a drive enable `mem_dq_oe`, so the tristate buffer stays at the pad. A read is answered with a one-cycle `rsp_rvalid` pulse and the captured word. A write is acknowledged with `wr_ack` during its data cycle. A new request may be taken in the final cycle of the current transfer, so consecutive accesses run without gaps. The one exception is a write that directly follows a read: the block then inserts a deselect cycle so the memory can release the bus before the controller drives it.

The state machine has six states:
- `ST_IDLE`: no access; ready.
- `ST_RD_ADDR`: read address cycle.
- `ST_RD_LATE`: second read cycle, used only with one wait state.
- `ST_WR_ADDR`: write address cycle.
- `ST_WR_DATA`: late-write data cycle.
- `ST_DESEL`: turnaround cycle.

Transitions:
- `ST_IDLE` moves to `ST_RD_ADDR` or `ST_WR_ADDR` when a request is accepted.
- `ST_RD_ADDR` moves to `ST_RD_LATE` when `cfg_wait` is 1. Otherwise it is the final read cycle.
- From the final read cycle (`ST_RD_ADDR` without wait, `ST_RD_LATE` with wait), the next state depends on the request accepted there. A read goes to `ST_RD_ADDR`, a write goes to `ST_DESEL`, and no request goes to `ST_IDLE`.
- `ST_DESEL` always moves to `ST_WR_ADDR`.
- `ST_WR_ADDR` always moves to `ST_WR_DATA`.
- From `ST_WR_DATA`, an accepted read goes to `ST_RD_ADDR`, an accepted write goes to `ST_WR_ADDR`, and no request goes to `ST_IDLE`.

Top module: `lwsram_ctrl`

## Requirements
- R1: After synchronous reset the outputs are in the idle state. `mem_cs_n`, `mem_strobe_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_be_n` is all ones, `mem_dq_oe`, `wr_ack` and `rsp_rvalid` are 0, and `req_ready` is 1.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. The address cycle of every access is the cycle right after acceptance. In it, `mem_cs_n` and `mem_strobe_n` are 0 and `mem_addr` equals the request address.
- R3: In the cycle after a write's address cycle, the block drives the late-write data. `mem_we_n` is 0, `mem_dq_oe` is 1, `mem_dq_out` equals the write data, `wr_ack` is 1, and `mem_cs_n` and `mem_strobe_n` are 1. In the following idle cycle `mem_we_n` is 1 and `mem_dq_oe` is 0.
- R4: With `cfg_wait`=0, `mem_dq_in` is sampled at the end of the read address cycle. `rsp_rvalid` is 1 in the next cycle, with that word on `rsp_rdata`.
- R5: With `cfg_wait`=1, `mem_dq_in` is sampled at the end of the cycle after the read address cycle. `rsp_rvalid` is 1 in the cycle after that.
- R6: `mem_oe_n` is 0 in every read cycle: the address cycle and, with `cfg_wait`=1, the cycle after it. It is 1 in write, deselect and idle cycles.
- R7: When a write is accepted in the final cycle of a read, the next cycle is a deselect cycle. In that cycle `mem_cs_n`, `mem_strobe_n` and `mem_oe_n` are 1 and `req_ready` is 0. The write address cycle follows it.
- R8: `mem_dq_oe` is 1 only in a write data cycle. It is never 1 while `mem_oe_n` is 0 or while the memory model drives the bus, and never in the cycle right after a read cycle.
- R9: A request accepted in the final cycle of a read or of a write data cycle has its address cycle in the very next cycle. This applies to read after read, write after write and read after write.
- R10: `req_ready` is 1 in idle, in the final read cycle and in the write data cycle. It is 0 in the write address cycle, in the deselect cycle, and in the read address cycle when `cfg_wait`=1.
- R11: Each read produces exactly one `rsp_rvalid` cycle. With `cfg_wait`=1, `rsp_rvalid` is never 1 on two consecutive cycles.
- R12: Bit i of `req_mask` enables byte i, which is data bits 8i+7 to 8i. In the write data cycle `mem_be_n` equals the bitwise inverse of the mask, and only the enabled bytes of the stored word change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wait | input | 1 | Read wait states: 0 or 1; static outside reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte write mask, bit i enables byte i |
| rsp_rvalid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read data |
| wr_ack | output | 1 | Write accepted by the memory (data cycle) |
| mem_addr | output | ADDR_W | Memory address |
| mem_strobe_n | output | 1 | Address strobe, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DATA_W/8 | Byte enables, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
The bench runs the same directed sequences in both wait-state settings. The sequences are a lone write, a lone read, a partial-mask write read back, read followed at once by write, read after read, write after write, and read after write. Each one is checked to the exact cycle. The lone accesses fix the basic latencies and strobe shapes. The chained ones show whether the controller stays gap-free where it should and adds the turnaround cycle only for read-then-write. A behavioural late-write memory model answers reads in the timing of the selected mode. This shows whether data is captured on the right edge. A monitor flags any cycle where controller and memory would both drive the bus.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_ADDR = 3'd1,
        ST_RD_LATE = 3'd2,
        ST_WR_ADDR = 3'd3,
        ST_WR_DATA = 3'd4,
        ST_DESEL   = 3'd5
    } lw_state_e;

endpackage

// File: rtl/lwsram_fsm.sv
module lwsram_fsm
    import lwsram_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_wait,
    input  logic      req_valid,
    input  logic      req_write,
    output lw_state_e state,
    output logic      req_ready,
    output logic      accept,
    output logic      rd_last
);

    lw_state_e state_q;
    lw_state_e state_d;
    lw_state_e rd_exit;
    lw_state_e wr_exit;

    assign state = state_q;

    // final read cycle, handshake and exit targets
    always_comb begin
        rd_last   = (state_q == ST_RD_LATE) || ((state_q == ST_RD_ADDR) && !cfg_wait);
        req_ready = (state_q == ST_IDLE) || (state_q == ST_WR_DATA) || rd_last;
        accept    = req_valid && req_ready;
        if (!accept)
            rd_exit = ST_IDLE;
        else if (req_write)
            rd_exit = ST_DESEL;
        else
            rd_exit = ST_RD_ADDR;
        if (!accept)
            wr_exit = ST_IDLE;
        else if (req_write)
            wr_exit = ST_WR_ADDR;
        else
            wr_exit = ST_RD_ADDR;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept)
                    state_d = req_write ? ST_WR_ADDR : ST_RD_ADDR;
            end
            ST_RD_ADDR: begin
                if (cfg_wait)
                    state_d = ST_RD_LATE;
                else
                    state_d = rd_exit;
            end
            ST_RD_LATE: state_d = rd_exit;
            ST_WR_ADDR: state_d = ST_WR_DATA;
            ST_WR_DATA: state_d = wr_exit;
            ST_DESEL:   state_d = ST_WR_ADDR;
            default:    state_d = ST_IDLE;
        endcase
    end

    AST_DESEL_GAP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WR_ADDR) |-> !$past(rd_last)); // R7

    AST_DESEL_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DESEL) |-> ($past(rd_last) && !req_ready)); // R7

endmodule

// File: rtl/lwsram_reqreg.sv
module lwsram_reqreg #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int NB = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  logic [NB-1:0] in_mask,
    output logic [AW-1:0] held_addr,
    output logic [DW-1:0] held_wdata,
    output logic [NB-1:0] held_mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_addr  <= '0;
            held_wdata <= '0;
            held_mask  <= '0;
        end else if (accept) begin
            held_addr  <= in_addr;
            held_wdata <= in_wdata;
            held_mask  <= in_mask;
        end
    end

endmodule

// File: rtl/lwsram_pins.sv
module lwsram_pins
    import lwsram_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int NB = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  lw_state_e     state,
    input  logic [AW-1:0] held_addr,
    input  logic [DW-1:0] held_wdata,
    input  logic [NB-1:0] held_mask,
    output logic [AW-1:0] mem_addr,
    output logic          mem_strobe_n,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic [NB-1:0] mem_be_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    output logic          wr_ack
);

    assign mem_addr = held_addr;

    // Moore decode of the memory pins from the registered state
    always_comb begin
        mem_strobe_n = 1'b1;
        mem_cs_n     = 1'b1;
        mem_we_n     = 1'b1;
        mem_be_n     = '1;
        mem_oe_n     = 1'b1;
        mem_dq_out   = '0;
        mem_dq_oe    = 1'b0;
        wr_ack       = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_RD_ADDR: begin
                mem_strobe_n = 1'b0;
                mem_cs_n     = 1'b0;
                mem_oe_n     = 1'b0;
            end
            ST_RD_LATE: begin
                mem_oe_n = 1'b0;
            end
            ST_WR_ADDR: begin
                mem_strobe_n = 1'b0;
                mem_cs_n     = 1'b0;
            end
            ST_WR_DATA: begin
                mem_we_n   = 1'b0;
                mem_be_n   = ~held_mask;
                mem_dq_out = held_wdata;
                mem_dq_oe  = 1'b1;
                wr_ack     = 1'b1;
            end
            ST_DESEL: begin
            end
            default: begin
            end
        endcase
    end

    AST_LATE_WRITE: assert property (@(posedge clk) disable iff (rst)
        $past(!mem_cs_n && mem_oe_n) |-> (!mem_we_n && mem_dq_oe)); // R3

    AST_DQ_NO_CLASH: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (mem_oe_n && mem_cs_n)); // R8

    AST_DQ_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        $past(!mem_oe_n) |-> !mem_dq_oe); // R8

endmodule

// File: rtl/lwsram_rdcap.sv
module lwsram_rdcap #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  logic [DW-1:0] dq_in,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= cap_en;
            if (cap_en)
                rdata <= dq_in;
        end
    end

endmodule

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wait,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_mask,
    output logic                  rsp_rvalid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  wr_ack,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_strobe_n,
    output logic                  mem_cs_n,
    output logic                  mem_we_n,
    output logic [DATA_W/8-1:0]   mem_be_n,
    output logic                  mem_oe_n,
    output logic [DATA_W-1:0]     mem_dq_out,
    output logic                  mem_dq_oe,
    input  logic [DATA_W-1:0]     mem_dq_in
);

    localparam int BYTES = DATA_W / 8;

    lw_state_e         state;
    logic              accept;
    logic              rd_last;
    logic [ADDR_W-1:0] held_addr;
    logic [DATA_W-1:0] held_wdata;
    logic [BYTES-1:0]  held_mask;

    lwsram_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cfg_wait  (cfg_wait),
        .req_valid (req_valid),
        .req_write (req_write),
        .state     (state),
        .req_ready (req_ready),
        .accept    (accept),
        .rd_last   (rd_last)
    );

    lwsram_reqreg #(.AW(ADDR_W), .DW(DATA_W), .NB(BYTES)) u_reqreg (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .in_addr    (req_addr),
        .in_wdata   (req_wdata),
        .in_mask    (req_mask),
        .held_addr  (held_addr),
        .held_wdata (held_wdata),
        .held_mask  (held_mask)
    );

    lwsram_pins #(.AW(ADDR_W), .DW(DATA_W), .NB(BYTES)) u_pins (
        .clk          (clk),
        .rst          (rst),
        .state        (state),
        .held_addr    (held_addr),
        .held_wdata   (held_wdata),
        .held_mask    (held_mask),
        .mem_addr     (mem_addr),
        .mem_strobe_n (mem_strobe_n),
        .mem_cs_n     (mem_cs_n),
        .mem_we_n     (mem_we_n),
        .mem_be_n     (mem_be_n),
        .mem_oe_n     (mem_oe_n),
        .mem_dq_out   (mem_dq_out),
        .mem_dq_oe    (mem_dq_oe),
        .wr_ack       (wr_ack)
    );

    lwsram_rdcap #(.DW(DATA_W)) u_rdcap (
        .clk    (clk),
        .rst    (rst),
        .cap_en (rd_last),
        .dq_in  (mem_dq_in),
        .rvalid (rsp_rvalid),
        .rdata  (rsp_rdata)
    );

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rsp_rvalid |-> $past(!mem_oe_n)); // R11

    AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (cfg_wait && rsp_rvalid) |=> !rsp_rvalid); // R11

    AST_WRITE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && mem_oe_n) |-> !req_ready); // R10

endmodule

// File: tb/lwsram_ctrl_test.sv
module lwsram_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NB = DW / 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wait = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NB-1:0] req_mask = '0;
    logic          rsp_rvalid;
    logic [DW-1:0] rsp_rdata;
    logic          wr_ack;
    logic [AW-1:0] mem_addr;
    logic          mem_strobe_n, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [NB-1:0] mem_be_n;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lwsram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .cfg_wait(cfg_wait),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata), .wr_ack(wr_ack),
        .mem_addr(mem_addr), .mem_strobe_n(mem_strobe_n), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    function automatic logic [DW-1:0] init_word(input logic [7:0] a);
        return {a, ~a, a ^ 8'h5A, 8'hC3};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [NB-1:0] m);
        logic [DW-1:0] r;
        r = old_w;
        for (int b = 0; b < NB; b++)
            if (m[b]) r[8*b +: 8] = new_w[8*b +: 8];
        return r;
    endfunction

    // behavioural late-write synchronous memory
    logic [DW-1:0] mem [256];
    logic [7:0]    lat_addr;
    logic          lat_wr, lat_rd;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_word(i[7:0]);
            lat_wr   <= 1'b0;
            lat_rd   <= 1'b0;
            lat_addr <= '0;
        end else begin
            if (lat_wr && !mem_we_n)
                for (int b = 0; b < NB; b++)
                    if (!mem_be_n[b]) mem[lat_addr][8*b +: 8] <= mem_dq_out[8*b +: 8];
            lat_wr <= !mem_cs_n && !mem_strobe_n && mem_oe_n;
            lat_rd <= !mem_cs_n && !mem_strobe_n && !mem_oe_n;
            if (!mem_cs_n) lat_addr <= mem_addr[7:0];
        end
    end

    logic model_drv;
    assign model_drv = cfg_wait ? lat_rd : (!mem_cs_n && !mem_oe_n);
    assign mem_dq_in = !model_drv ? 32'h0BAD_F00D :
                       (cfg_wait ? mem[lat_addr] : mem[mem_addr[7:0]]);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // contention monitor (R8)
    logic prev_drv = 1'b0;
    always @(negedge clk) begin
        if (!rst && mem_dq_oe) begin
            chk("R8 controller drives while memory drives", {63'd0, model_drv}, 64'd0);
            chk("R8 controller drives right after read", {63'd0, prev_drv}, 64'd0);
        end
        prev_drv <= !rst && (model_drv || !mem_oe_n);
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic no_req();
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic drive(input bit w, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [NB-1:0] m);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        req_mask  = m;
    endtask

    task automatic t_reset(input bit ws);
        rst = 1'b1;
        cfg_wait = ws;
        no_req();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 cs_n", {63'd0, mem_cs_n}, 64'd1);
        chk("R1 strobe_n", {63'd0, mem_strobe_n}, 64'd1);
        chk("R1 we_n", {63'd0, mem_we_n}, 64'd1);
        chk("R1 oe_n", {63'd0, mem_oe_n}, 64'd1);
        chk("R1 be_n", {60'd0, mem_be_n}, 64'hF);
        chk("R1 dq_oe", {63'd0, mem_dq_oe}, 64'd0);
        chk("R1 ready", {63'd0, req_ready}, 64'd1);
        chk("R1 rvalid/wr_ack", {62'd0, rsp_rvalid, wr_ack}, 64'd0);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] m);
        drive(1'b1, a, d, m);
        step();
        no_req();
        chk("R2 write addr cycle cs/strobe", {62'd0, mem_cs_n, mem_strobe_n}, 64'd0);
        chk("R2 write addr", {48'd0, mem_addr}, {48'd0, a});
        chk("R6 oe_n in write addr", {63'd0, mem_oe_n}, 64'd1);
        chk("R10 ready low in write addr", {63'd0, req_ready}, 64'd0);
        step();
        chk("R3 we_n/dq_oe/wr_ack", {61'd0, mem_we_n, mem_dq_oe, wr_ack}, 64'b011);
        chk("R3 dq_out", {32'd0, mem_dq_out}, {32'd0, d});
        chk("R3 cs deasserted in data cycle", {62'd0, mem_cs_n, mem_strobe_n}, 64'b11);
        chk("R12 be_n", {60'd0, mem_be_n}, {60'd0, ~m});
        chk("R10 ready in write data", {63'd0, req_ready}, 64'd1);
        step();
        chk("R3 released after write", {61'd0, mem_we_n, mem_dq_oe, wr_ack}, 64'b100);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] e);
        drive(1'b0, a, '0, '0);
        step();
        no_req();
        chk("R2 read addr cycle cs/strobe", {62'd0, mem_cs_n, mem_strobe_n}, 64'd0);
        chk("R2 read addr", {48'd0, mem_addr}, {48'd0, a});
        chk("R6 oe_n in read addr", {63'd0, mem_oe_n}, 64'd0);
        if (cfg_wait) begin
            chk("R10 ready low in waited read addr", {63'd0, req_ready}, 64'd0);
            step();
            chk("R6 oe_n in late read", {63'd0, mem_oe_n}, 64'd0);
            chk("R5 no data yet", {63'd0, rsp_rvalid}, 64'd0);
            chk("R10 ready in late read", {63'd0, req_ready}, 64'd1);
        end else begin
            chk("R10 ready in zero-wait read", {63'd0, req_ready}, 64'd1);
        end
        step();
        chk(cfg_wait ? "R5 rvalid" : "R4 rvalid", {63'd0, rsp_rvalid}, 64'd1);
        chk(cfg_wait ? "R5 rdata" : "R4 rdata", {32'd0, rsp_rdata}, {32'd0, e});
        chk("R6 oe_n after read", {63'd0, mem_oe_n}, 64'd1);
        step();
        chk("R11 rvalid single", {63'd0, rsp_rvalid}, 64'd0);
    endtask

    task automatic t_rd_wr(input logic [AW-1:0] ra, input logic [DW-1:0] re,
                           input logic [AW-1:0] wa, input logic [DW-1:0] wd, input logic [NB-1:0] wm);
        drive(1'b0, ra, '0, '0);
        step();
        if (cfg_wait) begin
            no_req();
            step();
        end
        chk("R10 ready in final read cycle", {63'd0, req_ready}, 64'd1);
        drive(1'b1, wa, wd, wm);
        step();
        no_req();
        chk("R7 deselect cs/strobe/oe", {61'd0, mem_cs_n, mem_strobe_n, mem_oe_n}, 64'b111);
        chk("R7 ready low in deselect", {63'd0, req_ready}, 64'd0);
        chk("R8 no drive in deselect", {63'd0, mem_dq_oe}, 64'd0);
        chk("R11 read data at deselect", {31'd0, rsp_rvalid, rsp_rdata}, {31'd0, 1'b1, re});
        step();
        chk("R7 write addr after deselect", {46'd0, mem_cs_n, mem_oe_n, mem_addr}, {46'd0, 1'b0, 1'b1, wa});
        chk("R11 no repeat rvalid", {63'd0, rsp_rvalid}, 64'd0);
        step();
        chk("R3 late data after turnaround", {31'd0, mem_dq_oe, mem_dq_out}, {31'd0, 1'b1, wd});
        step();
    endtask

    task automatic t_rd_rd(input logic [AW-1:0] a1, input logic [DW-1:0] e1,
                           input logic [AW-1:0] a2, input logic [DW-1:0] e2);
        drive(1'b0, a1, '0, '0);
        step();
        if (cfg_wait) begin
            no_req();
            step();
        end
        drive(1'b0, a2, '0, '0);
        step();
        no_req();
        chk("R9 second read addr without gap", {47'd0, mem_cs_n, mem_addr}, {47'd0, 1'b0, a2});
        chk("R9 first read data", {31'd0, rsp_rvalid, rsp_rdata}, {31'd0, 1'b1, e1});
        if (cfg_wait) begin
            step();
            chk("R11 rvalid gap in wait mode", {63'd0, rsp_rvalid}, 64'd0);
        end
        step();
        chk("R9 second read data", {31'd0, rsp_rvalid, rsp_rdata}, {31'd0, 1'b1, e2});
        step();
        chk("R11 rvalid ends", {63'd0, rsp_rvalid}, 64'd0);
    endtask

    task automatic t_wr_wr(input logic [AW-1:0] a1, input logic [DW-1:0] d1, input logic [NB-1:0] m1,
                           input logic [AW-1:0] a2, input logic [DW-1:0] d2, input logic [NB-1:0] m2);
        drive(1'b1, a1, d1, m1);
        step();
        no_req();
        step();
        chk("R3 first write data", {32'd0, mem_dq_out}, {32'd0, d1});
        drive(1'b1, a2, d2, m2);
        step();
        no_req();
        chk("R9 second write addr without gap", {47'd0, mem_cs_n, mem_addr}, {47'd0, 1'b0, a2});
        step();
        chk("R12 second write be_n", {60'd0, mem_be_n}, {60'd0, ~m2});
        chk("R3 second write data", {31'd0, mem_dq_oe, mem_dq_out}, {31'd0, 1'b1, d2});
        step();
    endtask

    task automatic t_wr_rd(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [NB-1:0] m, input logic [DW-1:0] e);
        drive(1'b1, a, d, m);
        step();
        no_req();
        step();
        drive(1'b0, a, '0, '0);
        step();
        no_req();
        chk("R9 read right after write", {46'd0, mem_cs_n, mem_oe_n, mem_addr}, {46'd0, 2'b00, a});
        if (cfg_wait) step();
        step();
        chk("R12 masked write read back", {31'd0, rsp_rvalid, rsp_rdata}, {31'd0, 1'b1, e});
        step();
    endtask

    task automatic run_mode(input bit ws);
        t_reset(ws);
        t_write(16'h0310, 32'h11223344, 4'b1111);
        t_read(16'h0310, 32'h11223344);
        t_read(16'h0021, init_word(8'h21));
        t_write(16'h0442, 32'hAABBCCDD, 4'b0101);
        t_read(16'h0442, merge(init_word(8'h42), 32'hAABBCCDD, 4'b0101));
        t_rd_wr(16'h0055, init_word(8'h55), 16'h0066, 32'h01020304, 4'b1000);
        t_rd_rd(16'h0077, init_word(8'h77), 16'h0066,
                merge(init_word(8'h66), 32'h01020304, 4'b1000));
        t_wr_wr(16'h0088, 32'h55667788, 4'b0011, 16'h0099, 32'h99AABBCC, 4'b1100);
        t_read(16'h0099, merge(init_word(8'h99), 32'h99AABBCC, 4'b1100));
        t_wr_rd(16'h00AA, 32'hCAFEF00D, 4'b0110, merge(init_word(8'hAA), 32'hCAFEF00D, 4'b0110));
    endtask

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule